// File: doc/BRIEF.md
# Interrupt Active-State Register Bank

This block holds the active flag of every interrupt on the distributor side of an interrupt controller. A bus master changes those flags through two address windows that act only on the bits written as 1. One window sets flags and the other clears them. Each access carries a byte offset, a data byte, the number of the requesting CPU and a secure/non-secure attribute. Each data byte covers eight consecutive interrupts.

The 32 internal interrupts (numbers 0 to 31) keep a separate active flag for each CPU, and an access touches only the copy of the CPU that issued it. Every higher interrupt has one flag that all CPUs share. When security checking is switched on, a non-secure access cannot change an interrupt that belongs to the secure group. The group is taken from a per-CPU vector for the internal interrupts and from a shared vector for the rest. An access to a byte beyond the configured interrupt count raises an error pulse and changes nothing. A combinational readback returns the addressed byte as the requesting CPU sees it. The full per-CPU view is also driven out for neighbouring logic.

Top module: `act_bank`

## Requirements
- R1: A write at byte offset 0x300..0x37F covers interrupts starting at first = (offset - 0x300) * 8. Data bit i addresses interrupt first + i. A 1 in that bit sets the interrupt's active flag, and a 0 leaves it unchanged. The new state is visible from the clock edge that samples the write.
- R2: A write at byte offset 0x380..0x3FF uses the same mapping, with first = (offset - 0x380) * 8. A 1 clears the active flag and a 0 leaves it unchanged.
- R3: For interrupts below 32, a write changes only the copy that belongs to `acc_cpu`. The copies of the other CPUs and the shared flags stay as they were.
- R4: For interrupts 32 and above, a write changes the single shared flag, and every CPU sees the change.
- R5: When `sec_chk_en` is 1 and `acc_secure` is 0, a data bit has no effect if its interrupt's group bit is 0. For interrupt n below 32 the group bit is `grp_banked[acc_cpu*32 + n]`, and otherwise it is `grp_shared[n]`. This holds for both windows.
- R6: When the access is secure, or `sec_chk_en` is 0, the group bits do not mask any data bit.
- R7: A valid access inside 0x300..0x3FF whose first interrupt is at or above NUM_IRQ drives `acc_err` high in the same cycle as `acc_valid` and no longer than that. No active flag changes, and `rd_data` is 0.
- R8: `rd_data` returns the active flags of the eight addressed interrupts as `acc_cpu` sees them, using the same mapping from either window. Bit i corresponds to interrupt first + i.
- R9: Reset clears every active flag of every CPU.
- R10: Read accesses (`acc_write` = 0) and accesses outside 0x300..0x3FF change no flag and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 12 | Byte offset of the access |
| acc_wdata | input | 8 | Write data byte |
| acc_cpu | input | CPU_W | Requesting CPU number |
| acc_secure | input | 1 | Access carries the secure attribute |
| sec_chk_en | input | 1 | Security checking enabled |
| grp_banked | input | NUM_CPU*32 | Per-CPU group bits for interrupts 0..31 |
| grp_shared | input | NUM_IRQ | Group bits for shared interrupts; bits 0..31 are unused |
| rd_data | output | 8 | Active flags of the addressed byte for acc_cpu |
| acc_err | output | 1 | Out-of-range access pulse |
| act_view | output | NUM_CPU*NUM_IRQ | Active flags as each CPU sees them, CPU c at [c*NUM_IRQ +: NUM_IRQ] |

## Verification
The bench writes mixed bit patterns such as 0xA5, 0x81 and 0xFF to banked bytes and to shared bytes, from both CPUs. It then reads each byte back from the same CPU and from the other CPU. This separates a per-CPU copy from a shared flag and checks that zero bits leave flags untouched. Non-secure writes run against partial group masks (0x0F, 0x3C) in both windows, once with checking enabled and once with it disabled. Secure writes run against the same masks, so an access that is wrongly masked shows up as a different pattern from one that is wrongly let through. The last byte in range, the first byte beyond it, and offsets just outside both windows test the range decode.

// File: rtl/act_bank_pkg.sv
package act_bank_pkg;
  localparam int INT_IRQ = 32;

  typedef enum logic [1:0] {WIN_NONE, WIN_SET, WIN_CLR} win_t;

  // Which write window an offset falls in.
  function automatic win_t win_of(input logic [11:0] off);
    if (off[11:7] == 5'b00110) return WIN_SET;
    if (off[11:7] == 5'b00111) return WIN_CLR;
    return WIN_NONE;
  endfunction

  // First interrupt covered by the byte at this offset (same in both windows).
  function automatic logic [9:0] first_irq_of(input logic [11:0] off);
    return {off[6:0], 3'b000};
  endfunction
endpackage

// File: rtl/act_decode.sv
module act_decode
  import act_bank_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int NUM_CPU = 2,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic [11:0]           offset,
  input  logic [CPU_W-1:0]      cpu,
  input  logic                  secure,
  input  logic                  sec_en,
  input  logic [7:0]            wdata,
  input  logic [NUM_CPU*32-1:0] grp_banked,
  input  logic [NUM_IRQ-1:0]    grp_shared,
  output logic                  hit_set,
  output logic                  hit_clr,
  output logic [9:0]            first_irq,
  output logic                  in_range,
  output logic [7:0]            wmask
);
  win_t win;

  always_comb begin
    win       = win_of(offset);
    hit_set   = (win == WIN_SET);
    hit_clr   = (win == WIN_CLR);
    first_irq = first_irq_of(offset);
    in_range  = (int'(first_irq) < NUM_IRQ);
  end

  // Per-bit group filter for non-secure accesses.
  always_comb begin
    for (int i = 0; i < 8; i++) begin
      int  irq;
      logic grp;
      irq = int'(first_irq) + i;
      grp = 1'b0;
      if (irq < INT_IRQ) begin
        if (int'(cpu) < NUM_CPU) grp = grp_banked[int'(cpu) * INT_IRQ + irq];
      end else if (irq < NUM_IRQ) begin
        grp = grp_shared[irq];
      end
      wmask[i] = wdata[i] & (secure | ~sec_en | grp);
    end
  end
endmodule

// File: rtl/act_store.sv
module act_store
  import act_bank_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int NUM_CPU = 2,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [CPU_W-1:0]           cpu,
  input  logic [NUM_IRQ-1:0]         set_vec,
  input  logic [NUM_IRQ-1:0]         clr_vec,
  output logic [NUM_CPU*NUM_IRQ-1:0] view
);
  logic [NUM_IRQ-1:INT_IRQ] shared_q;

  always_ff @(posedge clk) begin
    if (!rst_n) shared_q <= '0;
    else if (we) shared_q <= (shared_q | set_vec[NUM_IRQ-1:INT_IRQ]) & ~clr_vec[NUM_IRQ-1:INT_IRQ];
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [INT_IRQ-1:0] banked_q;
    always_ff @(posedge clk) begin
      if (!rst_n) banked_q <= '0;
      else if (we && int'(cpu) == c)
        banked_q <= (banked_q | set_vec[INT_IRQ-1:0]) & ~clr_vec[INT_IRQ-1:0];
    end
    assign view[c*NUM_IRQ +: NUM_IRQ] = {shared_q, banked_q};
  end
endmodule

// File: rtl/act_bank.sv
module act_bank
  import act_bank_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int NUM_CPU = 2,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  input  logic                       acc_write,
  input  logic [11:0]                acc_offset,
  input  logic [7:0]                 acc_wdata,
  input  logic [CPU_W-1:0]           acc_cpu,
  input  logic                       acc_secure,
  input  logic                       sec_chk_en,
  input  logic [NUM_CPU*32-1:0]      grp_banked,
  input  logic [NUM_IRQ-1:0]         grp_shared,
  output logic [7:0]                 rd_data,
  output logic                       acc_err,
  output logic [NUM_CPU*NUM_IRQ-1:0] act_view
);
  logic                hit_set, hit_clr, in_range, upd_en;
  logic [9:0]          first_irq;
  logic [7:0]          wmask;
  logic [NUM_IRQ-1:0]  upd_vec, set_vec, clr_vec;

  act_decode #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_dec (
    .offset(acc_offset), .cpu(acc_cpu), .secure(acc_secure), .sec_en(sec_chk_en),
    .wdata(acc_wdata), .grp_banked(grp_banked), .grp_shared(grp_shared),
    .hit_set(hit_set), .hit_clr(hit_clr), .first_irq(first_irq),
    .in_range(in_range), .wmask(wmask)
  );

  assign acc_err = acc_valid & (hit_set | hit_clr) & ~in_range;
  assign upd_en  = acc_valid & acc_write & (hit_set | hit_clr) & in_range;
  assign upd_vec = upd_en ? (NUM_IRQ'(wmask) << first_irq) : '0;
  assign set_vec = hit_set ? upd_vec : '0;
  assign clr_vec = hit_clr ? upd_vec : '0;

  act_store #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_store (
    .clk(clk), .rst_n(rst_n), .we(upd_en), .cpu(acc_cpu),
    .set_vec(set_vec), .clr_vec(clr_vec), .view(act_view)
  );

  always_comb begin
    rd_data = '0;
    if ((hit_set | hit_clr) && in_range && int'(acc_cpu) < NUM_CPU)
      rd_data = act_view[int'(acc_cpu) * NUM_IRQ + int'(first_irq) +: 8];
  end
endmodule

// File: rtl/act_bank_chk.sv
module act_bank_chk #(
  parameter int NUM_IRQ = 96,
  parameter int NUM_CPU = 2,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       acc_valid,
  input logic                       acc_write,
  input logic [7:0]                 acc_wdata,
  input logic [CPU_W-1:0]           acc_cpu,
  input logic                       acc_secure,
  input logic                       acc_err,
  input logic                       hit_set,
  input logic                       hit_clr,
  input logic [9:0]                 first_irq,
  input logic [NUM_CPU*NUM_IRQ-1:0] act_view
);
  logic wr_ok;
  assign wr_ok = acc_valid && acc_write && (hit_set || hit_clr) && !acc_err;

  AST_SET_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && hit_set && acc_secure && acc_wdata[0] && int'(acc_cpu) < NUM_CPU)
    |=> act_view[int'($past(acc_cpu)) * NUM_IRQ + int'($past(first_irq))]); // R1

  AST_CLR_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && hit_clr && acc_secure && acc_wdata[0] && int'(acc_cpu) < NUM_CPU)
    |=> !act_view[int'($past(acc_cpu)) * NUM_IRQ + int'($past(first_irq))]); // R2

  AST_BANKED_KEEPS_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && first_irq < 10'd32) |=> $stable(act_view[NUM_IRQ-1:32])); // R3

  AST_ERR_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> acc_valid); // R7

  AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> $stable(act_view)); // R7

  AST_IDLE_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write && (hit_set || hit_clr)) |=> $stable(act_view)); // R10

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (act_view == '0)); // R9
endmodule

bind act_bank act_bank_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_wdata(acc_wdata), .acc_cpu(acc_cpu), .acc_secure(acc_secure),
  .acc_err(acc_err), .hit_set(hit_set), .hit_clr(hit_clr),
  .first_irq(first_irq), .act_view(act_view)
);

// File: tb/act_bank_test.sv
module act_bank_test;
  localparam int NIRQ = 96;
  localparam int NCPU = 2;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, acc_secure = 1, sec_chk_en = 1;
  logic [11:0] acc_offset = '0;
  logic [7:0] acc_wdata = '0;
  logic [0:0] acc_cpu = '0;
  logic [NCPU*32-1:0] grp_banked = '1;
  logic [NIRQ-1:0] grp_shared = '1;
  logic [7:0] rd_data;
  logic acc_err;
  logic [NCPU*NIRQ-1:0] act_view;

  int n_chk = 0, n_fail = 0;

  act_bank #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_offset(acc_offset), .acc_wdata(acc_wdata), .acc_cpu(acc_cpu),
    .acc_secure(acc_secure), .sec_chk_en(sec_chk_en), .grp_banked(grp_banked),
    .grp_shared(grp_shared), .rd_data(rd_data), .acc_err(acc_err), .act_view(act_view)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic [11:0] off;
    logic [7:0]  data;
    logic        cpu;
    logic        exp_err;
    logic [7:0]  exp_rd;
  } vec_t;

  // Secure writes; readback from the same CPU at the same byte of the set window.
  localparam vec_t VECS [8] = '{
    '{12'h300, 8'hA5, 1'b0, 1'b0, 8'hA5},  // R1 banked set
    '{12'h300, 8'h0F, 1'b1, 1'b0, 8'h0F},  // R3 other CPU copy
    '{12'h380, 8'h05, 1'b0, 1'b0, 8'hA0},  // R2 clear, zeros untouched
    '{12'h304, 8'h81, 1'b1, 1'b0, 8'h81},  // R4 shared set
    '{12'h384, 8'h01, 1'b0, 1'b0, 8'h80},  // R4 shared clear by other CPU
    '{12'h30B, 8'hFF, 1'b0, 1'b0, 8'hFF},  // R7 last byte in range
    '{12'h30C, 8'hFF, 1'b0, 1'b1, 8'h00},  // R7 first byte beyond range
    '{12'h38B, 8'h0F, 1'b1, 1'b0, 8'hF0}   // R2 clear upper byte
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] off, input logic [7:0] d, input logic cpu,
                    input logic sec, input logic exp_err, input string req);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_offset = off; acc_wdata = d;
    acc_cpu = cpu; acc_secure = sec;
    #1 chk(acc_err === exp_err, req, int'(acc_err), int'(exp_err));
    @(negedge clk);
    acc_valid = 0; acc_write = 0; acc_secure = 1;
  endtask

  task automatic rd(input logic [11:0] off, input logic cpu, output logic [7:0] v);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_offset = off; acc_cpu = cpu;
    #1 v = rd_data;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic rd_chk(input logic [11:0] off, input logic cpu, input logic [7:0] exp,
                        input string req);
    logic [7:0] v;
    rd(off, cpu, v);
    chk(v === exp, req, int'(v), int'(exp));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    rd_chk(12'h300, 1'b0, 8'h00, "R9 reset cpu0");
    rd_chk(12'h304, 1'b1, 8'h00, "R9 reset shared");

    for (int k = 0; k < 8; k++) begin
      vec_t v;
      v = VECS[k];
      wr(v.off, v.data, v.cpu, 1'b1, v.exp_err, $sformatf("R7 err vec %0d", k));
      rd_chk(v.off & ~12'h080, v.cpu, v.exp_rd, $sformatf("R1/R2 vec %0d", k));
    end

    // R3 / R4 cross-CPU views
    rd_chk(12'h300, 1'b1, 8'h0F, "R3 cpu1 copy");
    rd_chk(12'h300, 1'b0, 8'hA0, "R3 cpu0 copy");
    rd_chk(12'h304, 1'b0, 8'h80, "R4 shared seen by cpu0");
    rd_chk(12'h38B, 1'b0, 8'hF0, "R8 read via clear window");

    // R5 banked group masking, per CPU
    grp_banked[8 +: 8] = 8'h0F;
    wr(12'h301, 8'hFF, 1'b0, 1'b0, 1'b0, "R5 err");
    rd_chk(12'h301, 1'b0, 8'h0F, "R5 banked mask cpu0");
    wr(12'h301, 8'hFF, 1'b1, 1'b0, 1'b0, "R5 err");
    rd_chk(12'h301, 1'b1, 8'hFF, "R5 cpu1 own group");

    // R5 shared masking, both windows; R6 secure bypass
    grp_shared[40 +: 8] = 8'h3C;
    wr(12'h305, 8'hFF, 1'b1, 1'b0, 1'b0, "R5 err");
    rd_chk(12'h305, 1'b1, 8'h3C, "R5 shared set mask");
    wr(12'h385, 8'hFF, 1'b1, 1'b0, 1'b0, "R5 err");
    rd_chk(12'h305, 1'b0, 8'h00, "R5 shared clear mask");
    wr(12'h305, 8'hFF, 1'b0, 1'b1, 1'b0, "R6 err");
    rd_chk(12'h305, 1'b0, 8'hFF, "R6 secure ignores group");
    wr(12'h385, 8'hFF, 1'b0, 1'b0, 1'b0, "R5 err");
    rd_chk(12'h305, 1'b0, 8'hC3, "R5 non-secure clear keeps secure bits");

    // R6 checking disabled
    grp_shared[48 +: 8] = 8'h00;
    sec_chk_en = 0;
    wr(12'h306, 8'hFF, 1'b0, 1'b0, 1'b0, "R6 err");
    rd_chk(12'h306, 1'b1, 8'hFF, "R6 checking off");
    sec_chk_en = 1;

    // R10 outside windows
    wr(12'h2FF, 8'hFF, 1'b0, 1'b1, 1'b0, "R10 below window no err");
    wr(12'h400, 8'hFF, 1'b0, 1'b1, 1'b0, "R10 above window no err");
    rd_chk(12'h300, 1'b0, 8'hA0, "R10 state unchanged");
    chk(act_view[NIRQ +: 8] === 8'h0F, "R10 view cpu1", int'(act_view[NIRQ +: 8]), 8'h0F);

    // R7 clear-window error, single-cycle pulse, zero readback
    wr(12'h38C, 8'hFF, 1'b1, 1'b1, 1'b1, "R7 clear window err");
    #1 chk(acc_err === 1'b0, "R7 pulse ends", int'(acc_err), 0);
    rd_chk(12'h3FF, 1'b0, 8'h00, "R7 out-of-range read");
    rd_chk(12'h38B, 1'b1, 8'hF0, "R7 no state change");

    // R9 reset mid-run
    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
    rd_chk(12'h304, 1'b0, 8'h00, "R9 shared cleared");
    rd_chk(12'h300, 1'b1, 8'h00, "R9 banked cleared");
    chk(act_view === '0, "R9 all cleared", int'(act_view[31:0]), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule